// File: doc/BRIEF.md
# Hardware Sprite Channel

This block is one sprite channel of a raster display pipeline. It holds two 16-bit image planes, a horizontal start, a vertical first line and a vertical last line. A comparator watches the beam's horizontal counter. When the counter reaches the start position on a line where the channel is armed, a two-plane serializer emits 16 pixels of 2-bit color index, one per clock. Index 0 is transparent, so the downstream mixer sees a valid flag only for visible pixels.

The registers can be loaded in two ways. In automatic mode, the channel asks for words in its own per-line fetch slot. At the top of a frame, and after each vertical stop, it asks for a control pair (position word, then stop word). Inside the vertical window it asks for a data pair on every line (plane 1, then plane 0). In processor mode, software writes the same four registers through a simple write port. A write to plane 0 arms the channel and a write to the stop word disarms it. A vertical reload after a stop lets the same channel show another object lower in the frame. A mid-line position rewrite lets it show again on the same line.

Top module: `sprite_channel`

## Requirements
- R1: After reset, pix_o is 0, pix_valid_o is low and, with dma_en_i low, dma_req_o is low.
- R2: A write to register 2 (plane 0) arms the channel. While armed, the clock edge at which hpos_i equals the horizontal start (register 0 bits [7:0]) is followed by 16 cycles in which cycle i shows pix_o = {plane1[15-i], plane0[15-i]}.
- R3: pix_valid_o is high only inside that 16-cycle window and only when pix_o is nonzero. Index 0 and all cycles outside the window give pix_valid_o low and pix_o 0.
- R4: A write to register 1 (stop word) disarms the channel, so a later horizontal match produces no pixels.
- R5: An armed channel fires again on the same line when register 0 is rewritten mid-line with a later horizontal start.
- R6: dma_req_o stays low while dma_en_i is low. After enable, the first request is a control pair (dma_ctl_o high). Words are taken on dma_wr_i while the request is high, position word first and stop word second. The request drops after the second word.
- R7: In automatic mode, a line_start_i with vpos_i equal to the vertical start (register 0 bits [15:8]) begins the window. On that line and on each later line of the window, a data pair is requested (plane 1 first, then plane 0), and it is displayed on the same line.
- R8: A line_start_i with vpos_i equal to the vertical stop (register 1 bits [7:0]) inside the window disarms the channel and requests a control pair on that line.
- R9: A control pair whose stop value is 0 turns the channel off. No request follows until a line_start_i with vpos_i equal to 0, which requests a control pair.
- R10: After a stop, a control pair with a later vertical start shows the sprite again further down the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hpos_i | input | 8 | Beam horizontal counter |
| vpos_i | input | 8 | Beam vertical counter |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| dma_en_i | input | 1 | Automatic fetch mode enable |
| dma_req_o | output | 1 | Channel wants its fetch slot on this line |
| dma_ctl_o | output | 1 | Requested pair is control (1) or image data (0) |
| dma_wr_i | input | 1 | Fetched word strobe |
| dma_data_i | input | 16 | Fetched word |
| reg_wr_i | input | 1 | Processor register write strobe |
| reg_addr_i | input | 2 | 0 position, 1 stop, 2 plane 0, 3 plane 1 |
| reg_data_i | input | 16 | Processor write data |
| pix_o | output | 2 | Color index, 0 outside the window |
| pix_valid_o | output | 1 | Non-transparent pixel present |

## Verification
The hardest situation to reach is a second vertical use of the channel within one frame. It needs a full window, a stop line that disarms and switches to a control fetch, a fresh pair with a later start, and a second window. The stimulus walks a short frame line by line, acting as the fetch engine and answering each request with chosen words. A stop word of zero then drives the channel off, and a line at vertical 0 wakes it. A processor rewrite of the horizontal start in the middle of a line covers horizontal reuse.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int COORD_W = 8;
  localparam int DATA_W  = 16;
  localparam int PIX_W   = 2;

  typedef enum logic [1:0] {
    REG_POS  = 2'd0,
    REG_STOP = 2'd1,
    REG_PL0  = 2'd2,
    REG_PL1  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SEQ_CTL,
    SEQ_WAIT,
    SEQ_DATA,
    SEQ_OFF
  } seq_st_e;
endpackage

// File: rtl/sprite_regs.sv
module sprite_regs import sprite_pkg::*; #(
  parameter int CW = COORD_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          disarm_i,
  output logic [CW-1:0] hstart_o,
  output logic [CW-1:0] vstart_o,
  output logic [CW-1:0] vstop_o,
  output logic [DW-1:0] pl0_o,
  output logic [DW-1:0] pl1_o,
  output logic          armed_o
);
  logic [DW-1:0] pos_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      stop_q  <= '0;
      pl0_o   <= '0;
      pl1_o   <= '0;
      armed_o <= 1'b0;
    end else begin
      if (disarm_i) armed_o <= 1'b0;
      if (wr_i) begin
        unique case (sel_i)
          REG_POS:  pos_q <= wdata_i;
          REG_STOP: begin stop_q <= wdata_i; armed_o <= 1'b0; end
          REG_PL0:  begin pl0_o <= wdata_i; armed_o <= 1'b1; end
          REG_PL1:  pl1_o <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign hstart_o = pos_q[CW-1:0];
  assign vstart_o = pos_q[DW-1 -: CW];
  assign vstop_o  = stop_q[CW-1:0];

  AST_ARM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == REG_PL0) |=> armed_o); // R2
  AST_ARM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == REG_STOP) |=> !armed_o); // R4
endmodule

// File: rtl/sprite_seq.sv
module sprite_seq import sprite_pkg::*; #(
  parameter int CW = COORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_en_i,
  input  logic          line_start_i,
  input  logic [CW-1:0] vpos_i,
  input  logic [CW-1:0] vstart_i,
  input  logic [CW-1:0] vstop_i,
  input  logic          dma_wr_i,
  input  logic [CW-1:0] new_stop_i,
  output logic          dma_req_o,
  output logic          dma_ctl_o,
  output logic          we_o,
  output reg_sel_e      sel_o,
  output logic          disarm_o
);
  seq_st_e st_q;
  logic    pend_q, widx_q, accept;

  assign dma_req_o = dma_en_i && (st_q == SEQ_CTL || (st_q == SEQ_DATA && pend_q));
  assign dma_ctl_o = (st_q == SEQ_CTL);
  assign accept    = dma_wr_i && dma_req_o;
  assign we_o      = accept;
  assign sel_o     = dma_ctl_o ? (widx_q ? REG_STOP : REG_POS) : (widx_q ? REG_PL0 : REG_PL1);
  // leaving the window drops the stale image before the control pair lands
  assign disarm_o  = dma_en_i && line_start_i && st_q == SEQ_DATA &&
                     (vpos_i == vstop_i || vpos_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_CTL;
      pend_q <= 1'b0;
      widx_q <= 1'b0;
    end else if (!dma_en_i) begin
      st_q   <= SEQ_CTL;
      pend_q <= 1'b0;
      widx_q <= 1'b0;
    end else if (line_start_i) begin
      widx_q <= 1'b0;
      pend_q <= 1'b0;
      if (vpos_i == '0) st_q <= SEQ_CTL;
      else begin
        unique case (st_q)
          SEQ_WAIT: if (vpos_i == vstart_i) begin st_q <= SEQ_DATA; pend_q <= 1'b1; end
          SEQ_DATA: if (vpos_i == vstop_i) st_q <= SEQ_CTL;
                    else pend_q <= 1'b1;
          default:  ;
        endcase
      end
    end else if (accept) begin
      widx_q <= ~widx_q;
      if (widx_q) begin
        if (st_q == SEQ_CTL) st_q <= (new_stop_i == '0) ? SEQ_OFF : SEQ_WAIT;
        else pend_q <= 1'b0;
      end
    end
  end

  AST_STOP_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && line_start_i && st_q == SEQ_DATA && vpos_i == vstop_i)
    |=> (!dma_en_i || (dma_ctl_o && dma_req_o))); // R8
  AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && widx_q && st_q == SEQ_CTL && new_stop_i == '0 && !line_start_i)
    |=> !dma_req_o); // R9
  AST_PAIR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && widx_q && st_q == SEQ_DATA && !line_start_i) |=> !dma_req_o); // R7
endmodule

// File: rtl/sprite_shifter.sv
module sprite_shifter import sprite_pkg::*; #(
  parameter int CW = COORD_W,
  parameter int DW = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    hpos_i,
  input  logic [CW-1:0]    hstart_i,
  input  logic             armed_i,
  input  logic [DW-1:0]    pl0_i,
  input  logic [DW-1:0]    pl1_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o
);
  localparam int CNT_W = $clog2(DW + 1);

  logic [DW-1:0]    sh0_q, sh1_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load, active;

  assign load = armed_i && (hpos_i == hstart_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh0_q <= '0;
      sh1_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh0_q <= pl0_i;
      sh1_q <= pl1_i;
      cnt_q <= CNT_W'(DW);
    end else if (active) begin
      sh0_q <= sh0_q << 1;
      sh1_q <= sh1_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active      = (cnt_q != '0);
  assign pix_o       = active ? {sh1_q[DW-1], sh0_q[DW-1]} : '0;
  assign pix_valid_o = active && (pix_o != '0);

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> pix_o == $past({pl1_i[DW-1], pl0_i[DW-1]})); // R2
  AST_WIN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && !load) |=> !pix_valid_o); // R3
endmodule

// File: rtl/sprite_channel.sv
module sprite_channel import sprite_pkg::*; #(
  parameter int CW = COORD_W,
  parameter int DW = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    hpos_i,
  input  logic [CW-1:0]    vpos_i,
  input  logic             line_start_i,
  input  logic             dma_en_i,
  output logic             dma_req_o,
  output logic             dma_ctl_o,
  input  logic             dma_wr_i,
  input  logic [DW-1:0]    dma_data_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_data_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o
);
  logic          seq_we, disarm, armed, wr;
  reg_sel_e      seq_sel, sel;
  logic [DW-1:0] wdata, pl0, pl1;
  logic [CW-1:0] hstart, vstart, vstop;

  // fetched word wins over a processor write in the same cycle
  assign wr    = seq_we | reg_wr_i;
  assign sel   = seq_we ? seq_sel : reg_sel_e'(reg_addr_i);
  assign wdata = seq_we ? dma_data_i : reg_data_i;

  sprite_seq #(.CW(CW)) u_seq (
    .clk_i, .rst_ni, .dma_en_i, .line_start_i, .vpos_i,
    .vstart_i(vstart), .vstop_i(vstop), .dma_wr_i,
    .new_stop_i(dma_data_i[CW-1:0]),
    .dma_req_o, .dma_ctl_o, .we_o(seq_we), .sel_o(seq_sel), .disarm_o(disarm)
  );

  sprite_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .sel_i(sel), .wdata_i(wdata), .disarm_i(disarm),
    .hstart_o(hstart), .vstart_o(vstart), .vstop_o(vstop),
    .pl0_o(pl0), .pl1_o(pl1), .armed_o(armed)
  );

  sprite_shifter #(.CW(CW), .DW(DW)) u_shift (
    .clk_i, .rst_ni, .hpos_i, .hstart_i(hstart), .armed_i(armed),
    .pl0_i(pl0), .pl1_i(pl1), .pix_o, .pix_valid_o
  );
endmodule

// File: tb/sprite_channel_test.sv
module sprite_channel_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  hpos, vpos;
  logic        line_start, dma_en, dma_req, dma_ctl, dma_wr, reg_wr, pix_valid;
  logic [15:0] dma_data, reg_data;
  logic [1:0]  reg_addr, pix;

  always #10 clk = ~clk;

  sprite_channel uut (
    .clk_i(clk), .rst_ni, .hpos_i(hpos), .vpos_i(vpos), .line_start_i(line_start),
    .dma_en_i(dma_en), .dma_req_o(dma_req), .dma_ctl_o(dma_ctl), .dma_wr_i(dma_wr),
    .dma_data_i(dma_data), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_data_i(reg_data),
    .pix_o(pix), .pix_valid_o(pix_valid)
  );

  typedef struct packed { logic v; logic [1:0] p; } exp_t;
  exp_t  q[$];
  exp_t  e;
  string cur_req = "R1";
  int    checks = 0, fails = 0;

  // reference model state
  logic [7:0]  m_h = '0;
  logic [15:0] m_p0 = '0, m_p1 = '0, m_s0 = '0, m_s1 = '0;
  logic        m_arm = 1'b0;
  int          m_cnt = 0;

  task automatic check(input string r, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // monitor: compares every output cycle against the queued expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if ({pix_valid, pix} !== {e.v, e.p}) begin
        fails++;
        $display("FAIL %s pixel @h=%0d v=%0d: actual %b/%0d expected %b/%0d",
                 cur_req, hpos, vpos, pix_valid, pix, e.v, e.p);
      end
    end
  end

  // src: 0 none, 1 fetched word, 2 processor write; addr is the register it must land in
  task automatic tick(input logic [7:0] h, input logic ls, input int src,
                      input logic [1:0] addr, input logic [15:0] data, input logic dis);
    exp_t x;
    hpos = h; line_start = ls;
    dma_wr = (src == 1); dma_data = data;
    reg_wr = (src == 2); reg_addr = addr; reg_data = data;
    @(posedge clk);
    if (m_arm && h == m_h) begin
      m_s0 = m_p0; m_s1 = m_p1; m_cnt = 16;
    end else if (m_cnt > 0) begin
      m_s0 = m_s0 << 1; m_s1 = m_s1 << 1; m_cnt--;
    end
    if (dis) m_arm = 1'b0;
    if (src != 0) begin
      case (addr)
        2'd0: m_h = data[7:0];
        2'd1: m_arm = 1'b0;
        2'd2: begin m_p0 = data; m_arm = 1'b1; end
        default: m_p1 = data;
      endcase
    end
    x.p = (m_cnt > 0) ? {m_s1[15], m_s0[15]} : 2'b00;
    x.v = (x.p != 2'b00);
    q.push_back(x);
    #1;
    dma_wr = 1'b0; reg_wr = 1'b0; line_start = 1'b0;
  endtask

  task automatic line(input logic [7:0] v, input logic ereq, input logic ectl,
                      input logic [15:0] wa, input logic [15:0] wb, input logic dis,
                      input logic [7:0] mh, input logic [15:0] md);
    vpos = v;
    tick(8'd0, 1'b1, 0, 2'd0, 16'h0, dis);
    check(cur_req, "request at line start", {15'b0, dma_req}, {15'b0, ereq});
    if (ereq) check(cur_req, "pair kind", {15'b0, dma_ctl}, {15'b0, ectl});
    tick(8'd1, 1'b0, ereq ? 1 : 0, ectl ? 2'd0 : 2'd3, wa, 1'b0);
    tick(8'd2, 1'b0, ereq ? 1 : 0, ectl ? 2'd1 : 2'd2, wb, 1'b0);
    if (ereq) check(cur_req, "request after pair", {15'b0, dma_req}, 16'h0);
    for (int h = 3; h < 120; h++)
      tick(8'(h), 1'b0, (mh != 0 && h == int'(mh)) ? 2 : 0, 2'd0, md, 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0; hpos = '0; vpos = '0; line_start = 1'b0; dma_en = 1'b0;
    dma_wr = 1'b0; dma_data = '0; reg_wr = 1'b0; reg_addr = '0; reg_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #2;
    // R1 reset state
    check("R1", "pix_valid after reset", {15'b0, pix_valid}, 16'h0);
    check("R1", "pix after reset", {14'b0, pix}, 16'h0);
    check("R1", "request after reset", {15'b0, dma_req}, 16'h0);

    // R2, R3: processor loads, transparent index 0 in plane pattern
    cur_req = "R2,R3";
    tick(8'd200, 1'b0, 2, 2'd0, 16'h0014, 1'b0);
    tick(8'd200, 1'b0, 2, 2'd3, 16'hA5F0, 1'b0);
    tick(8'd200, 1'b0, 2, 2'd2, 16'h3C0F, 1'b0);
    line(8'd10, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd0, 16'h0);

    // R5: horizontal reuse by mid-line position rewrite
    cur_req = "R5";
    line(8'd11, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd50, 16'h0050);

    // R4: stop-word write disarms
    cur_req = "R4";
    tick(8'd200, 1'b0, 2, 2'd1, 16'h0000, 1'b0);
    line(8'd12, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd0, 16'h0);
    check("R6", "request while disabled", {15'b0, dma_req}, 16'h0);

    // R6: enable, control pair first
    cur_req = "R6";
    dma_en = 1'b1;
    line(8'd1, 1'b1, 1'b1, 16'h031E, 16'h0005, 1'b0, 8'd0, 16'h0);
    // R7: window from line 3, data pair each line
    cur_req = "R7";
    line(8'd2, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd0, 16'h0);
    line(8'd3, 1'b1, 1'b0, 16'h8001, 16'hFFFF, 1'b0, 8'd0, 16'h0);
    line(8'd4, 1'b1, 1'b0, 16'h1234, 16'h00F0, 1'b0, 8'd0, 16'h0);
    // R8: stop line disarms and asks for control pair
    cur_req = "R8";
    line(8'd5, 1'b1, 1'b1, 16'h073C, 16'h0008, 1'b1, 8'd0, 16'h0);
    // R10: second use lower in the frame
    cur_req = "R10";
    line(8'd6, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd0, 16'h0);
    line(8'd7, 1'b1, 1'b0, 16'hF00F, 16'h0FF0, 1'b0, 8'd0, 16'h0);
    // R9: zero stop turns channel off until vertical 0
    cur_req = "R9";
    line(8'd8, 1'b1, 1'b1, 16'h0A28, 16'h0000, 1'b1, 8'd0, 16'h0);
    line(8'd9, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd0, 16'h0);
    line(8'd10, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'd0, 16'h0);
    line(8'd0, 1'b1, 1'b1, 16'h0A28, 16'h0000, 1'b0, 8'd0, 16'h0);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule